// File: doc/BRIEF.md
# Four-Slot Bundle Issue Gate with Register Scoreboard

The block sits between bundle decode and the execution units of a statically scheduled wide-issue core. Every cycle it looks at one bundle of four operation slots and decides whether the whole bundle may issue. A slot carries an operation class, a destination register and two source registers. Three conditions must hold together. The classes in the bundle must fit the unit counts. Every source of every active slot must have finished its producer's latency. No slot may read or write a register that another slot in the same bundle writes.

Accepted bundles load a per-register countdown with the latency of the unit class that produces the result. A register is readable again once its countdown reaches zero. A bundle that fails any check is held: ready stays low, nothing in it issues, and the checks run again on the next cycle with the same or updated inputs. All units are pipelined, so back-to-back bundles of the same class are accepted whenever the sources are ready. Register 0 is a constant sink. It is always readable, and writes to it leave no trace.

Top module: `vliw_issue_gate`

## Requirements
- R1: After reset every register is readable, so a legal bundle reading any registers is accepted on the first cycle.
- R2: A bundle with more than 2 load slots (class code 2'b01) is rejected. Exactly 2 loads together with one add/sub and one multiply is accepted.
- R3: A bundle with more than 2 add/sub slots (class code 2'b10) is rejected.
- R4: A bundle with more than 1 multiply slot (class code 2'b11) is rejected.
- R5: A load's destination may be read by a bundle 3 cycles after the load issued, and not earlier.
- R6: An add/sub destination may be read 2 cycles after issue, and not earlier.
- R7: A multiply destination may be read 4 cycles after issue, and not earlier.
- R8: Several slots of one bundle may read the same register.
- R9: A bundle is rejected if any active slot reads a nonzero register that another active slot in the same bundle writes, whatever the slot order.
- R10: A bundle in which two active slots write the same nonzero register is rejected.
- R11: bnd_issue equals bnd_valid and bnd_ready, and bnd_stall equals bnd_valid and not bnd_ready. A rejected bundle changes no register's readiness.
- R12: Register 0 is always readable. Writing it starts no countdown and creates no conflict inside the bundle.
- R13: A slot of class code 2'b00 (empty) uses no unit, and its destination and source fields are ignored.
- R14: Units are pipelined: bundles that each hold one multiply are accepted on consecutive cycles, and each result keeps its own countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bnd_valid | input | 1 | A bundle is presented |
| slot_cls | input | SLOTS*2 | Class per slot: 00 empty, 01 load, 10 add/sub, 11 multiply |
| slot_dst | input | SLOTS*log2(NREG) | Destination register per slot |
| slot_src_a | input | SLOTS*log2(NREG) | First source register per slot (0 when unused) |
| slot_src_b | input | SLOTS*log2(NREG) | Second source register per slot (0 when unused) |
| bnd_ready | output | 1 | The presented bundle passes all checks |
| bnd_issue | output | 1 | The bundle issues on this edge |
| bnd_stall | output | 1 | A bundle is presented but is held |

## Verification
Every cycle, the bound checker confirms the limits that gate acceptance. These are the per-class unit caps, the absence of read-after-write and duplicate-destination pairs inside any accepted bundle, the rule that any issued destination is unreadable on the next cycle, and the rule that a cycle without issue never makes a register unreadable. The exact latency for each class, the cycle on which a held consumer is released, shared reads, the exemptions for register 0 and empty slots, and the pipelined back-to-back flow can only be shown by the directed scenarios. Each of those scenarios samples readiness cycle by cycle against a count worked out from the requirements.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;

    typedef enum logic [1:0] {
        OPC_NOP   = 2'b00,
        OPC_LOAD  = 2'b01,
        OPC_ARITH = 2'b10,
        OPC_MUL   = 2'b11
    } op_class_e;

endpackage

// File: rtl/unit_budget.sv
module unit_budget
    import vliw_issue_pkg::*;
#(
    parameter int SLOTS     = 4,
    parameter int LD_UNITS  = 2,
    parameter int AR_UNITS  = 2,
    parameter int MUL_UNITS = 1
) (
    input  logic [SLOTS-1:0][1:0] cls,
    output logic                  budget_ok
);

    localparam int CNTW = $clog2(SLOTS + 1);

    logic [CNTW-1:0] n_ld;
    logic [CNTW-1:0] n_ar;
    logic [CNTW-1:0] n_mul;

    always_comb begin
        n_ld  = '0;
        n_ar  = '0;
        n_mul = '0;
        for (int s = 0; s < SLOTS; s++) begin
            unique case (op_class_e'(cls[s]))
                OPC_LOAD:  n_ld  = n_ld  + CNTW'(1);
                OPC_ARITH: n_ar  = n_ar  + CNTW'(1);
                OPC_MUL:   n_mul = n_mul + CNTW'(1);
                default:   ;
            endcase
        end
        budget_ok = (int'(n_ld)  <= LD_UNITS) &&
                    (int'(n_ar)  <= AR_UNITS) &&
                    (int'(n_mul) <= MUL_UNITS);
    end

endmodule

// File: rtl/bundle_hazard.sv
module bundle_hazard
    import vliw_issue_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int NREG  = 64
) (
    input  logic [SLOTS-1:0][1:0]              cls,
    input  logic [SLOTS-1:0][$clog2(NREG)-1:0] dst,
    input  logic [SLOTS-1:0][$clog2(NREG)-1:0] src_a,
    input  logic [SLOTS-1:0][$clog2(NREG)-1:0] src_b,
    output logic                               hazard_free
);

    localparam int RW = $clog2(NREG);

    logic [SLOTS-1:0] act;
    logic [SLOTS-1:0] writes;

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            act[s]    = (op_class_e'(cls[s]) != OPC_NOP);
            writes[s] = act[s] && (dst[s] != RW'(0));
        end
    end

    always_comb begin
        hazard_free = 1'b1;
        for (int i = 0; i < SLOTS; i++) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (i != j && act[i] && writes[j]) begin
                    if (src_a[i] == dst[j] || src_b[i] == dst[j])
                        hazard_free = 1'b0;
                    if (i < j && dst[i] == dst[j])
                        hazard_free = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
    import vliw_issue_pkg::*;
#(
    parameter int SLOTS   = 4,
    parameter int NREG    = 64,
    parameter int LD_LAT  = 3,
    parameter int AR_LAT  = 2,
    parameter int MUL_LAT = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SLOTS-1:0][1:0]              cls,
    input  logic [SLOTS-1:0][$clog2(NREG)-1:0] dst,
    output logic [NREG-1:0]                    rdy_vec
);

    localparam int RW     = $clog2(NREG);
    localparam int MAXLAT = (LD_LAT > AR_LAT)
                          ? ((LD_LAT > MUL_LAT) ? LD_LAT : MUL_LAT)
                          : ((AR_LAT > MUL_LAT) ? AR_LAT : MUL_LAT);
    localparam int CW     = $clog2(MAXLAT + 1);

    function automatic logic [CW-1:0] wait_of(input logic [1:0] c);
        unique case (op_class_e'(c))
            OPC_LOAD:  return CW'(LD_LAT - 1);
            OPC_ARITH: return CW'(AR_LAT - 1);
            OPC_MUL:   return CW'(MUL_LAT - 1);
            default:   return '0;
        endcase
    endfunction

    assign rdy_vec[0] = 1'b1;

    for (genvar r = 1; r < NREG; r++) begin : g_reg
        logic [CW-1:0] cnt_q;
        logic          hit;
        logic [CW-1:0] load_val;

        always_comb begin
            hit      = 1'b0;
            load_val = '0;
            for (int s = 0; s < SLOTS; s++) begin
                if (wr_en && op_class_e'(cls[s]) != OPC_NOP &&
                    dst[s] == RW'(r)) begin
                    hit      = 1'b1;
                    load_val = wait_of(cls[s]);
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (hit)
                cnt_q <= load_val;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CW'(1);
        end

        assign rdy_vec[r] = (cnt_q == '0);
    end

endmodule

// File: rtl/vliw_issue_gate.sv
module vliw_issue_gate
    import vliw_issue_pkg::*;
#(
    parameter int SLOTS     = 4,
    parameter int NREG      = 64,
    parameter int LD_UNITS  = 2,
    parameter int AR_UNITS  = 2,
    parameter int MUL_UNITS = 1,
    parameter int LD_LAT    = 3,
    parameter int AR_LAT    = 2,
    parameter int MUL_LAT   = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bnd_valid,
    input  logic [SLOTS-1:0][1:0]              slot_cls,
    input  logic [SLOTS-1:0][$clog2(NREG)-1:0] slot_dst,
    input  logic [SLOTS-1:0][$clog2(NREG)-1:0] slot_src_a,
    input  logic [SLOTS-1:0][$clog2(NREG)-1:0] slot_src_b,
    output logic                               bnd_ready,
    output logic                               bnd_issue,
    output logic                               bnd_stall
);

    logic [NREG-1:0] rdy_vec;
    logic            budget_ok;
    logic            hazard_free;
    logic            srcs_ok;

    unit_budget #(
        .SLOTS(SLOTS), .LD_UNITS(LD_UNITS),
        .AR_UNITS(AR_UNITS), .MUL_UNITS(MUL_UNITS)
    ) u_budget (
        .cls      (slot_cls),
        .budget_ok(budget_ok)
    );

    bundle_hazard #(
        .SLOTS(SLOTS), .NREG(NREG)
    ) u_hazard (
        .cls        (slot_cls),
        .dst        (slot_dst),
        .src_a      (slot_src_a),
        .src_b      (slot_src_b),
        .hazard_free(hazard_free)
    );

    reg_scoreboard #(
        .SLOTS(SLOTS), .NREG(NREG),
        .LD_LAT(LD_LAT), .AR_LAT(AR_LAT), .MUL_LAT(MUL_LAT)
    ) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bnd_issue),
        .cls    (slot_cls),
        .dst    (slot_dst),
        .rdy_vec(rdy_vec)
    );

    always_comb begin
        srcs_ok = 1'b1;
        for (int s = 0; s < SLOTS; s++) begin
            if (op_class_e'(slot_cls[s]) != OPC_NOP &&
                !(rdy_vec[slot_src_a[s]] && rdy_vec[slot_src_b[s]]))
                srcs_ok = 1'b0;
        end
    end

    always_comb begin
        bnd_ready = budget_ok & hazard_free & srcs_ok;
        bnd_issue = bnd_valid & bnd_ready;
        bnd_stall = bnd_valid & ~bnd_ready;
    end

endmodule

// File: rtl/issue_gate_props.sv
module issue_gate_props #(
    parameter int SLOTS     = 4,
    parameter int NREG      = 64,
    parameter int LD_UNITS  = 2,
    parameter int AR_UNITS  = 2,
    parameter int MUL_UNITS = 1
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               bnd_ready,
    input logic                               bnd_issue,
    input logic [SLOTS-1:0][1:0]              slot_cls,
    input logic [SLOTS-1:0][$clog2(NREG)-1:0] slot_dst,
    input logic [SLOTS-1:0][$clog2(NREG)-1:0] slot_src_a,
    input logic [SLOTS-1:0][$clog2(NREG)-1:0] slot_src_b,
    input logic [NREG-1:0]                    rdy_vec
);

    function automatic int n_of(input logic [SLOTS-1:0][1:0] c,
                                input logic [1:0] k);
        int n = 0;
        for (int s = 0; s < SLOTS; s++)
            if (c[s] == k) n++;
        return n;
    endfunction

    a_r2_load_cap: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_ready |-> n_of(slot_cls, 2'b01) <= LD_UNITS);

    a_r3_arith_cap: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_ready |-> n_of(slot_cls, 2'b10) <= AR_UNITS);

    a_r4_mul_cap: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_ready |-> n_of(slot_cls, 2'b11) <= MUL_UNITS);

    // R11: a cycle without issue never turns a readable register unreadable
    a_r11_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_issue |=> ((~rdy_vec & $past(rdy_vec)) == '0));

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // R5, R6, R7: each class latency is at least two cycles by default
        a_r5_dst_pending: assert property (@(posedge clk) disable iff (!rst_n)
            (bnd_issue && slot_cls[i] != 2'b00 && slot_dst[i] != '0)
            |=> !rdy_vec[$past(slot_dst[i])]);

        for (genvar j = 0; j < SLOTS; j++) begin : g_pair
            if (i != j) begin : g_ne
                a_r9_intra_raw: assert property (@(posedge clk) disable iff (!rst_n)
                    bnd_ready |-> !(slot_cls[i] != 2'b00 && slot_cls[j] != 2'b00 &&
                                    slot_dst[j] != '0 &&
                                    (slot_src_a[i] == slot_dst[j] ||
                                     slot_src_b[i] == slot_dst[j])));
            end
            if (i < j) begin : g_lt
                a_r10_dup_dst: assert property (@(posedge clk) disable iff (!rst_n)
                    bnd_ready |-> !(slot_cls[i] != 2'b00 && slot_cls[j] != 2'b00 &&
                                    slot_dst[i] != '0 && slot_dst[i] == slot_dst[j]));
            end
        end
    end

endmodule

bind vliw_issue_gate issue_gate_props #(
    .SLOTS(SLOTS), .NREG(NREG), .LD_UNITS(LD_UNITS),
    .AR_UNITS(AR_UNITS), .MUL_UNITS(MUL_UNITS)
) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd_ready (bnd_ready),
    .bnd_issue (bnd_issue),
    .slot_cls  (slot_cls),
    .slot_dst  (slot_dst),
    .slot_src_a(slot_src_a),
    .slot_src_b(slot_src_b),
    .rdy_vec   (rdy_vec)
);

// File: tb/vliw_issue_gate_test.sv
module vliw_issue_gate_test;

    localparam logic [1:0] NOP = 2'b00, LD = 2'b01, AR = 2'b10, ML = 2'b11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid = 1'b0;
    logic [3:0][1:0] cls = '0;
    logic [3:0][5:0] dst = '0;
    logic [3:0][5:0] sa  = '0;
    logic [3:0][5:0] sb  = '0;
    logic            ready, issue, stall;
    int              n_chk = 0;
    int              n_bad = 0;

    always #4 clk = ~clk;

    vliw_issue_gate uut (
        .clk(clk), .rst_n(rst_n), .bnd_valid(valid),
        .slot_cls(cls), .slot_dst(dst), .slot_src_a(sa), .slot_src_b(sb),
        .bnd_ready(ready), .bnd_issue(issue), .bnd_stall(stall)
    );

    task automatic put(input int i, input logic [1:0] c, input int d,
                       input int a, input int b);
        cls[i] = c; dst[i] = 6'(d); sa[i] = 6'(a); sb[i] = 6'(b);
        valid  = 1'b1;
    endtask

    task automatic clr();
        cls = '0; dst = '0; sa = '0; sb = '0; valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_rdy(input string tag, input logic exp);
        #1;
        n_chk++;
        if (ready !== exp || issue !== (valid & exp) || stall !== (valid & ~exp)) begin
            n_bad++;
            $display("FAIL %s: ready/issue/stall=%b%b%b expected %b%b%b",
                     tag, ready, issue, stall, exp, valid & exp, valid & ~exp);
        end
    endtask

    task automatic drain();
        clr();
        repeat (6) tick();
    endtask

    task automatic t_reset();
        clr();
        expect_rdy("R1 idle after reset", 1'b1);
        put(0, AR, 3, 63, 1); put(1, LD, 4, 62, 0);
        expect_rdy("R1 all registers readable", 1'b1);
        tick(); drain();
    endtask

    task automatic t_budget();
        put(0, LD, 1, 10, 0); put(1, LD, 2, 10, 0); put(2, LD, 3, 10, 0);
        expect_rdy("R2 three loads", 1'b0);
        clr();
        put(0, LD, 1, 10, 0); put(1, LD, 2, 11, 0);
        put(2, AR, 3, 12, 13); put(3, ML, 4, 14, 15);
        expect_rdy("R2 two loads full bundle", 1'b1);
        tick(); drain();
        put(0, AR, 1, 10, 0); put(1, AR, 2, 10, 0); put(2, AR, 3, 10, 0);
        expect_rdy("R3 three add/sub", 1'b0);
        clr();
        put(0, ML, 1, 10, 11); put(1, ML, 2, 12, 13);
        expect_rdy("R4 two multiplies", 1'b0);
        drain();
    endtask

    task automatic t_latency(input string tag, input logic [1:0] c, input int lat);
        put(0, c, 5, 10, 0);
        expect_rdy({tag, " producer"}, 1'b1);
        tick(); clr();
        put(0, AR, 2, 5, 10);
        for (int k = 1; k <= lat; k++) begin
            expect_rdy(tag, (k == lat));
            tick();
        end
        drain();
    endtask

    task automatic t_shared();
        put(0, LD, 1, 10, 0); put(1, LD, 3, 10, 0); put(2, AR, 8, 10, 20);
        expect_rdy("R8 shared reads of one register", 1'b1);
        tick(); drain();
    endtask

    task automatic t_intra();
        put(0, ML, 14, 13, 12); put(1, AR, 15, 14, 0);
        expect_rdy("R9 later slot reads earlier write", 1'b0);
        clr();
        put(0, AR, 15, 0, 14); put(3, ML, 14, 13, 12);
        expect_rdy("R9 earlier slot reads later write", 1'b0);
        clr();
        put(1, AR, 8, 20, 0); put(2, AR, 8, 21, 0);
        expect_rdy("R10 duplicate destination", 1'b0);
        drain();
    endtask

    task automatic t_reject();
        put(0, LD, 5, 10, 0); put(1, AR, 6, 10, 0);
        put(2, AR, 7, 10, 0); put(3, AR, 9, 10, 0);
        expect_rdy("R11 over budget held", 1'b0);
        tick();
        expect_rdy("R11 still held", 1'b0);
        tick(); clr();
        put(0, AR, 2, 5, 6);
        expect_rdy("R11 rejected bundle left no countdown", 1'b1);
        tick(); drain();
    endtask

    task automatic t_zero();
        put(0, ML, 0, 10, 11);
        expect_rdy("R12 multiply into r0", 1'b1);
        tick(); clr();
        put(0, AR, 2, 0, 0);
        expect_rdy("R12 r0 readable next cycle", 1'b1);
        clr();
        put(0, AR, 0, 10, 0); put(1, AR, 3, 0, 0); put(2, LD, 0, 0, 0);
        expect_rdy("R12 r0 no bundle conflict", 1'b1);
        tick(); drain();
    endtask

    task automatic t_nop();
        put(0, NOP, 21, 20, 20); put(1, AR, 20, 21, 0);
        put(2, AR, 22, 0, 0);    put(3, NOP, 22, 22, 22);
        expect_rdy("R13 empty slot fields ignored", 1'b1);
        tick(); clr();
        put(0, LD, 30, 10, 0);
        expect_rdy("R13 producer", 1'b1);
        tick(); clr();
        put(0, NOP, 30, 30, 30); put(1, NOP, 0, 30, 0);
        put(2, NOP, 0, 0, 0);    put(3, NOP, 0, 0, 0);
        expect_rdy("R13 empty slot reads pending register", 1'b1);
        drain();
    endtask

    task automatic t_pipe();
        for (int k = 0; k < 3; k++) begin
            clr(); put(0, ML, 40 + k, 10, 11);
            expect_rdy("R14 back-to-back multiply", 1'b1);
            tick();
        end
        clr(); put(0, AR, 2, 40, 0);
        expect_rdy("R14 first result not yet ready", 1'b0);
        tick();
        expect_rdy("R14 first result ready at four", 1'b1);
        clr(); put(0, AR, 2, 42, 0);
        expect_rdy("R14 third result still pending", 1'b0);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_budget();
        t_latency("R5 load latency", LD, 3);
        t_latency("R6 add/sub latency", AR, 2);
        t_latency("R7 multiply latency", ML, 4);
        t_shared();
        t_intra();
        t_reject();
        t_zero();
        t_nop();
        t_pipe();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule